// File: doc/BRIEF.md
# Gapped Strided Copy Engine

This block moves a programmed number of bytes from one region of memory to another, where the source and the destination each have their own line shape. On the read side the engine walks a line of a programmed width, then jumps over a programmed gap before the next line. On the write side it does the same with a width and a gap that are independent of the read side. Widths and gaps are given in 16-byte units. The total byte count is given in bytes and need not be a multiple of 16.

Data moves over a 128-bit path, one 16-byte beat at a time. Each beat is one read request, one returned data word and one write with byte enables. The size of every beat is the smallest of three values: the bytes left in the current source line, the bytes left in the current destination line, and the bytes left in the whole copy, capped at the beat size.

A start pulse in the idle state samples the whole configuration and raises the busy (trigger) bit. When the last byte has been written, busy drops and a one-cycle completion interrupt fires. A zero line width on either side is a configuration error. In that case the engine finishes at once, moves no data and sets an error flag.

Top module: `sdma_copy`

## Requirements
- R1: A `start` pulse while the engine is idle (`busy` and `done_irq` both low), with both widths nonzero and a nonzero total, raises `busy` in the next cycle. `busy` then stays high until the copy completes.
- R2: A source width value w and gap value g mean w*16 and g*16 bytes. After w*16 bytes have been read from consecutive addresses, the next read address is g*16 bytes past the end of that line.
- R3: A destination width value w and gap value g mean w*16 and g*16 bytes. After w*16 bytes have been written to consecutive addresses, the next write address is g*16 bytes past the end of that line.
- R4: Each beat carries min(bytes left in source line, bytes left in destination line, bytes left in total, 16) bytes. Such a beat has `wr_be` bits 0..n-1 set, where lane i is byte address `wr_addr`+i on `wr_data[8i+7:8i]`. A copy of T bytes therefore takes ceil(T/16) write beats.
- R5: Exactly the expected destination bytes are written with the source bytes in order. Every other destination byte is left unchanged.
- R6: On completion, `busy` is low and `done_irq` is high for exactly one cycle, and the interrupt fires once per copy.
- R7: If the source or destination width value is zero at start, `done_irq` is high in the cycle after the start edge, `err_flag` is set, and no read or write request is made. The next accepted start with a valid configuration clears `err_flag`.
- R8: A total of zero with valid widths completes in the cycle after start with `err_flag` low and no memory traffic.
- R9: `start` is ignored while a copy is running. The running copy's configuration and result are unchanged, and only one interrupt fires.
- R10: A read request (`rd_valid`, `rd_addr`) and a write request (`wr_valid`, `wr_addr`, `wr_data`, `wr_be`) hold steady until accepted by their ready. At most one read is outstanding, and a write is raised only after its read data has returned.
- R11: The low four bits of the base addresses are ignored, so every `rd_addr` and `wr_addr` is 16-byte aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Trigger pulse, accepted only when idle |
| cfg_src_addr | input | ADDR_W | Source base byte address |
| cfg_dst_addr | input | ADDR_W | Destination base byte address |
| cfg_total | input | SIZE_W | Total bytes to copy |
| cfg_in_width | input | UNIT_W | Source line width, 16-byte units |
| cfg_in_gap | input | UNIT_W | Source gap after each line, 16-byte units |
| cfg_out_width | input | UNIT_W | Destination line width, 16-byte units |
| cfg_out_gap | input | UNIT_W | Destination gap after each line, 16-byte units |
| busy | output | 1 | Trigger bit, high while a copy runs |
| done_irq | output | 1 | One-cycle completion interrupt |
| err_flag | output | 1 | Last accepted start had a zero width |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | ADDR_W | Read beat address |
| rd_rvalid | input | 1 | Read data returned |
| rd_rdata | input | DATA_W | Read data |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | ADDR_W | Write beat address |
| wr_data | output | DATA_W | Write data |
| wr_be | output | DATA_W/8 | Write byte enables |

## Verification
The bench builds the engine with ADDR_W=16, SIZE_W=12 and UNIT_W=4. A 16-bit address fits a 4 KiB byte model on both sides, a 12-bit total allows copies of a few hundred bytes, and 4-bit units give lines and gaps of up to 240 bytes. At these sizes, copies cross many line boundaries on both sides in unrelated patterns. They end on partial beats and exercise zero gaps, uneven width ratios and unaligned bases. Random ready and read-return delays put every handshake under back-pressure.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_RWAIT,
    ST_WRITE,
    ST_FIN
  } sdma_state_e;
endpackage

// File: rtl/sdma_chunk.sv
module sdma_chunk #(
  parameter int CNT_W      = 16,
  parameter int BEAT_BYTES = 16,
  localparam int BEAT_W    = $clog2(BEAT_BYTES) + 1
) (
  input  logic [CNT_W-1:0]      in_left,
  input  logic [CNT_W-1:0]      out_left,
  input  logic [CNT_W-1:0]      tot_left,
  output logic [BEAT_W-1:0]     beat_len,
  output logic [BEAT_BYTES-1:0] beat_be
);
  logic [CNT_W-1:0] line_min;
  logic [CNT_W-1:0] chunk_len;

  // chunk = smallest of the three remaining counts; a beat is at most one bus word
  always_comb begin
    line_min  = (in_left < out_left) ? in_left : out_left;
    chunk_len = (line_min < tot_left) ? line_min : tot_left;
    if (chunk_len >= CNT_W'(BEAT_BYTES)) beat_len = BEAT_W'(BEAT_BYTES);
    else                                 beat_len = chunk_len[BEAT_W-1:0];
  end

  for (genvar g = 0; g < BEAT_BYTES; g++) begin : g_lane
    assign beat_be[g] = (BEAT_W'(g) < beat_len);
  end
endmodule

// File: rtl/sdma_addr_seq.sv
module sdma_addr_seq #(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 24,
  parameter int UNIT_W     = 8,
  parameter int BEAT_BYTES = 16,
  localparam int SHIFT     = $clog2(BEAT_BYTES),
  localparam int LINE_W    = UNIT_W + SHIFT,
  localparam int CNT_W     = (LINE_W > SIZE_W) ? LINE_W : SIZE_W,
  localparam int BEAT_W    = SHIFT + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] cfg_src_addr,
  input  logic [ADDR_W-1:0] cfg_dst_addr,
  input  logic [SIZE_W-1:0] cfg_total,
  input  logic [UNIT_W-1:0] cfg_in_width,
  input  logic [UNIT_W-1:0] cfg_in_gap,
  input  logic [UNIT_W-1:0] cfg_out_width,
  input  logic [UNIT_W-1:0] cfg_out_gap,
  input  logic [BEAT_W-1:0] beat_len,
  output logic [ADDR_W-1:0] src_ptr,
  output logic [ADDR_W-1:0] dst_ptr,
  output logic [CNT_W-1:0]  in_left,
  output logic [CNT_W-1:0]  out_left,
  output logic [CNT_W-1:0]  tot_left,
  output logic              last
);
  logic [ADDR_W-1:0] src_q, src_d, dst_q, dst_d;
  logic [CNT_W-1:0]  inl_q, inl_d, outl_q, outl_d, tot_q, tot_d;
  logic [LINE_W-1:0] in_w_q, in_g_q, out_w_q, out_g_q;
  logic [CNT_W-1:0]  beat_c, in_rem, out_rem;
  logic [ADDR_W-1:0] beat_a, align_mask;

  assign beat_c     = CNT_W'(beat_len);
  assign beat_a     = ADDR_W'(beat_len);
  assign align_mask = ~ADDR_W'(BEAT_BYTES - 1);
  assign in_rem     = inl_q - beat_c;
  assign out_rem    = outl_q - beat_c;

  always_comb begin
    src_d  = src_q;
    dst_d  = dst_q;
    inl_d  = inl_q;
    outl_d = outl_q;
    tot_d  = tot_q;
    if (load) begin
      src_d  = cfg_src_addr & align_mask;
      dst_d  = cfg_dst_addr & align_mask;
      inl_d  = CNT_W'({cfg_in_width, {SHIFT{1'b0}}});
      outl_d = CNT_W'({cfg_out_width, {SHIFT{1'b0}}});
      tot_d  = CNT_W'(cfg_total);
    end else if (step) begin
      tot_d = tot_q - beat_c;
      if (in_rem == '0) begin
        inl_d = CNT_W'(in_w_q);
        src_d = src_q + beat_a + ADDR_W'(in_g_q);
      end else begin
        inl_d = in_rem;
        src_d = src_q + beat_a;
      end
      if (out_rem == '0) begin
        outl_d = CNT_W'(out_w_q);
        dst_d  = dst_q + beat_a + ADDR_W'(out_g_q);
      end else begin
        outl_d = out_rem;
        dst_d  = dst_q + beat_a;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      inl_q  <= '0;
      outl_q <= '0;
      tot_q  <= '0;
    end else if (load || step) begin
      src_q  <= src_d;
      dst_q  <= dst_d;
      inl_q  <= inl_d;
      outl_q <= outl_d;
      tot_q  <= tot_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_w_q  <= '0;
      in_g_q  <= '0;
      out_w_q <= '0;
      out_g_q <= '0;
    end else if (load) begin
      in_w_q  <= {cfg_in_width, {SHIFT{1'b0}}};
      in_g_q  <= {cfg_in_gap, {SHIFT{1'b0}}};
      out_w_q <= {cfg_out_width, {SHIFT{1'b0}}};
      out_g_q <= {cfg_out_gap, {SHIFT{1'b0}}};
    end
  end

  assign src_ptr  = src_q;
  assign dst_ptr  = dst_q;
  assign in_left  = inl_q;
  assign out_left = outl_q;
  assign tot_left = tot_q;
  assign last     = (tot_q == beat_c);

  // beat never exceeds any remaining count (R4)
  assert_beat_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (beat_len != '0) && (beat_c <= inl_q) && (beat_c <= outl_q) && (beat_c <= tot_q));

  // source line counter reloads to full width after the line is used up (R2)
  assert_in_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && (inl_q == beat_c)) |=> (inl_q == CNT_W'(in_w_q)));

  // destination line counter reloads to full width after the line is used up (R3)
  assert_out_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && (outl_q == beat_c)) |=> (outl_q == CNT_W'(out_w_q)));
endmodule

// File: rtl/sdma_ctrl.sv
module sdma_ctrl
  import sdma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cfg_err,
  input  logic cfg_empty,
  input  logic rd_ready,
  input  logic rd_rvalid,
  input  logic wr_ready,
  input  logic last,
  output logic busy,
  output logic done_irq,
  output logic err_flag,
  output logic rd_valid,
  output logic wr_valid,
  output logic load,
  output logic step,
  output logic capture
);
  sdma_state_e state_q, state_d;
  logic        err_q;
  logic        accept;

  assign accept = (state_q == ST_IDLE) && start;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = (cfg_err || cfg_empty) ? ST_FIN : ST_READ;
      ST_READ:  if (rd_ready) state_d = ST_RWAIT;
      ST_RWAIT: if (rd_rvalid) state_d = ST_WRITE;
      ST_WRITE: if (wr_ready) state_d = last ? ST_FIN : ST_READ;
      ST_FIN:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (accept) err_q <= cfg_err;
  end

  assign load     = accept;
  assign rd_valid = (state_q == ST_READ);
  assign wr_valid = (state_q == ST_WRITE);
  assign busy     = rd_valid || wr_valid || (state_q == ST_RWAIT);
  assign done_irq = (state_q == ST_FIN);
  assign err_flag = err_q;
  assign step     = wr_valid && wr_ready;
  assign capture  = (state_q == ST_RWAIT) && rd_rvalid;

  assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  assert_err_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> (!rd_valid && !wr_valid));

  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !step) |=> busy);
endmodule

// File: rtl/sdma_copy.sv
module sdma_copy #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 24,
  parameter int UNIT_W = 8,
  parameter int DATA_W = 128,
  localparam int BEAT_BYTES = DATA_W / 8,
  localparam int SHIFT      = $clog2(BEAT_BYTES),
  localparam int LINE_W     = UNIT_W + SHIFT,
  localparam int CNT_W      = (LINE_W > SIZE_W) ? LINE_W : SIZE_W,
  localparam int BEAT_W     = SHIFT + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [ADDR_W-1:0]     cfg_src_addr,
  input  logic [ADDR_W-1:0]     cfg_dst_addr,
  input  logic [SIZE_W-1:0]     cfg_total,
  input  logic [UNIT_W-1:0]     cfg_in_width,
  input  logic [UNIT_W-1:0]     cfg_in_gap,
  input  logic [UNIT_W-1:0]     cfg_out_width,
  input  logic [UNIT_W-1:0]     cfg_out_gap,
  output logic                  busy,
  output logic                  done_irq,
  output logic                  err_flag,
  output logic                  rd_valid,
  input  logic                  rd_ready,
  output logic [ADDR_W-1:0]     rd_addr,
  input  logic                  rd_rvalid,
  input  logic [DATA_W-1:0]     rd_rdata,
  output logic                  wr_valid,
  input  logic                  wr_ready,
  output logic [ADDR_W-1:0]     wr_addr,
  output logic [DATA_W-1:0]     wr_data,
  output logic [BEAT_BYTES-1:0] wr_be
);
  logic              load, step, capture, last;
  logic              cfg_err, cfg_empty;
  logic [CNT_W-1:0]  in_left, out_left, tot_left;
  logic [BEAT_W-1:0] beat_len;
  logic [DATA_W-1:0] data_q;

  assign cfg_err   = (cfg_in_width == '0) || (cfg_out_width == '0);
  assign cfg_empty = (cfg_total == '0);

  sdma_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cfg_err   (cfg_err),
    .cfg_empty (cfg_empty),
    .rd_ready  (rd_ready),
    .rd_rvalid (rd_rvalid),
    .wr_ready  (wr_ready),
    .last      (last),
    .busy      (busy),
    .done_irq  (done_irq),
    .err_flag  (err_flag),
    .rd_valid  (rd_valid),
    .wr_valid  (wr_valid),
    .load      (load),
    .step      (step),
    .capture   (capture)
  );

  sdma_addr_seq #(
    .ADDR_W     (ADDR_W),
    .SIZE_W     (SIZE_W),
    .UNIT_W     (UNIT_W),
    .BEAT_BYTES (BEAT_BYTES)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .load          (load),
    .step          (step),
    .cfg_src_addr  (cfg_src_addr),
    .cfg_dst_addr  (cfg_dst_addr),
    .cfg_total     (cfg_total),
    .cfg_in_width  (cfg_in_width),
    .cfg_in_gap    (cfg_in_gap),
    .cfg_out_width (cfg_out_width),
    .cfg_out_gap   (cfg_out_gap),
    .beat_len      (beat_len),
    .src_ptr       (rd_addr),
    .dst_ptr       (wr_addr),
    .in_left       (in_left),
    .out_left      (out_left),
    .tot_left      (tot_left),
    .last          (last)
  );

  sdma_chunk #(
    .CNT_W      (CNT_W),
    .BEAT_BYTES (BEAT_BYTES)
  ) u_chunk (
    .in_left  (in_left),
    .out_left (out_left),
    .tot_left (tot_left),
    .beat_len (beat_len),
    .beat_be  (wr_be)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (capture) data_q <= rd_rdata;
  end

  assign wr_data = data_q;

  assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !done_irq && !cfg_err && !cfg_empty) |=> busy);

  assert_busy_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  assert_wr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_be)));

  assert_rd_align_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_addr[SHIFT-1:0] == '0));

  assert_wr_align_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr[SHIFT-1:0] == '0));
endmodule

// File: tb/sdma_copy_tb.sv
`timescale 1ns/1ps
module sdma_copy_tb;
  localparam int ADDR_W = 16;
  localparam int SIZE_W = 12;
  localparam int UNIT_W = 4;
  localparam int DATA_W = 128;
  localparam int NB     = DATA_W / 8;
  localparam int MEM    = 4096;

  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic              start;
  logic [ADDR_W-1:0] cfg_src_addr, cfg_dst_addr;
  logic [SIZE_W-1:0] cfg_total;
  logic [UNIT_W-1:0] cfg_in_width, cfg_in_gap, cfg_out_width, cfg_out_gap;
  logic              busy, done_irq, err_flag;
  logic              rd_valid, rd_ready, rd_rvalid;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_rdata, wr_data;
  logic              wr_valid, wr_ready;
  logic [NB-1:0]     wr_be;

  sdma_copy #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .UNIT_W(UNIT_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr), .cfg_total(cfg_total),
    .cfg_in_width(cfg_in_width), .cfg_in_gap(cfg_in_gap),
    .cfg_out_width(cfg_out_width), .cfg_out_gap(cfg_out_gap),
    .busy(busy), .done_irq(done_irq), .err_flag(err_flag),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be)
  );

  logic [7:0] src_mem [MEM];
  logic [7:0] dst_mem [MEM];
  logic [7:0] exp_mem [MEM];

  int checks = 0;
  int fails  = 0;
  int irq_cnt, wr_beats;
  bit proto_bad, align_bad;

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // memory responder: random back-pressure and read latency
  initial begin : responder
    bit              pend;
    int              dly;
    logic [ADDR_W-1:0] pa, prev_ra, prev_wa;
    bit              prev_rv, prev_rr, prev_wv, prev_wr;
    rd_ready = 1'b0; wr_ready = 1'b0; rd_rvalid = 1'b0; rd_rdata = '0;
    pend = 0; dly = 0; pa = '0; prev_ra = '0; prev_wa = '0;
    prev_rv = 0; prev_rr = 0; prev_wv = 0; prev_wr = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        pend = 0; rd_ready = 1'b0; wr_ready = 1'b0; rd_rvalid = 1'b0;
        prev_rv = 0; prev_wv = 0;
        continue;
      end
      if (done_irq) irq_cnt++;
      if (prev_rv && !prev_rr && (!rd_valid || rd_addr != prev_ra)) proto_bad = 1;
      if (prev_wv && !prev_wr && (!wr_valid || wr_addr != prev_wa)) proto_bad = 1;
      if (wr_valid && (pend || rd_valid)) proto_bad = 1;
      if (rd_valid && pend) proto_bad = 1;
      if (rd_valid && rd_addr[3:0] != 4'd0) align_bad = 1;
      if (wr_valid && wr_addr[3:0] != 4'd0) align_bad = 1;
      rd_rvalid = 1'b0;
      rd_ready  = 1'b0;
      if (pend) begin
        if (dly == 0) begin
          for (int i = 0; i < NB; i++) rd_rdata[8*i +: 8] = src_mem[(int'(pa) + i) % MEM];
          rd_rvalid = 1'b1;
          pend = 0;
        end else dly--;
      end else if (rd_valid && ($urandom % 4) != 0) begin
        rd_ready = 1'b1;
        pend = 1;
        pa = rd_addr;
        dly = $urandom % 3;
      end
      wr_ready = (($urandom % 3) != 0);
      if (wr_valid && wr_ready) begin
        for (int i = 0; i < NB; i++)
          if (wr_be[i]) dst_mem[(int'(wr_addr) + i) % MEM] = wr_data[8*i +: 8];
        wr_beats++;
      end
      prev_rv = rd_valid; prev_rr = rd_ready; prev_ra = rd_addr;
      prev_wv = wr_valid; prev_wr = wr_ready; prev_wa = wr_addr;
    end
  end

  // one copy: build expected image byte by byte, run, compare
  task automatic run_copy(string req, int src, int dst, int tot, int iw, int ig,
                          int ow, int og, bit poke);
    int sp, dp, inr, outr, rem, n, mism, first_bad;
    bit exp_err, quick;
    exp_err = (iw == 0) || (ow == 0);
    quick   = exp_err || (tot == 0);
    for (int i = 0; i < MEM; i++) begin
      dst_mem[i] = 8'((i * 7 + 3) ^ (i >> 5));
      exp_mem[i] = dst_mem[i];
    end
    if (!exp_err) begin
      sp = src & ~15; dp = dst & ~15; inr = iw * 16; outr = ow * 16; rem = tot;
      while (rem > 0) begin
        exp_mem[dp % MEM] = src_mem[sp % MEM];
        sp++; dp++; rem--; inr--; outr--;
        if (inr == 0) begin inr = iw * 16; sp += ig * 16; end
        if (outr == 0) begin outr = ow * 16; dp += og * 16; end
      end
    end
    irq_cnt = 0; wr_beats = 0; proto_bad = 0; align_bad = 0;
    @(negedge clk);
    cfg_src_addr = ADDR_W'(src); cfg_dst_addr = ADDR_W'(dst); cfg_total = SIZE_W'(tot);
    cfg_in_width = UNIT_W'(iw); cfg_in_gap = UNIT_W'(ig);
    cfg_out_width = UNIT_W'(ow); cfg_out_gap = UNIT_W'(og);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (quick) begin
      chk(done_irq == 1'b1, exp_err ? "R7" : "R8", {req, " immediate irq"}, done_irq, 1);
    end else begin
      chk(busy == 1'b1, "R1", {req, " busy after start"}, busy, 1);
      if (poke) begin
        repeat (3) @(negedge clk);
        cfg_src_addr = 16'h0300; cfg_total = 12'd16; cfg_in_width = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9", {req, " busy after ignored start"}, busy, 1);
      end
    end
    n = 0;
    while (!done_irq && n < 20000) begin @(negedge clk); n++; end
    chk(n < 20000, "R6", {req, " completion within limit"}, n, 0);
    chk(busy == 1'b0, "R6", {req, " busy low with irq"}, busy, 0);
    chk(err_flag == exp_err, "R7", {req, " error flag"}, err_flag, exp_err);
    repeat (3) @(negedge clk);
    chk(irq_cnt == 1, "R6", {req, " irq count"}, irq_cnt, 1);
    mism = 0; first_bad = -1;
    for (int i = 0; i < MEM; i++)
      if (dst_mem[i] !== exp_mem[i]) begin
        mism++;
        if (first_bad < 0) first_bad = i;
      end
    if (mism != 0)
      $display("FAIL R5 %s first bad byte @%0d: actual %0d expected %0d", req, first_bad,
               dst_mem[first_bad], exp_mem[first_bad]);
    chk(mism == 0, "R5", {req, " destination bytes differing"}, mism, 0);
    chk(wr_beats == (exp_err ? 0 : (tot + 15) / 16), "R4", {req, " write beats"}, wr_beats,
        exp_err ? 0 : (tot + 15) / 16);
    chk(!proto_bad, "R10", {req, " handshake order/hold"}, proto_bad, 0);
    chk(!align_bad, "R11", {req, " beat alignment"}, align_bad, 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd2024));
    for (int i = 0; i < MEM; i++) src_mem[i] = 8'((i * 37 + 11) ^ (i >> 8));
    start = 1'b0;
    cfg_src_addr = '0; cfg_dst_addr = '0; cfg_total = '0;
    cfg_in_width = '0; cfg_in_gap = '0; cfg_out_width = '0; cfg_out_gap = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && done_irq == 1'b0, "R6", "reset busy/irq", {busy, done_irq}, 0);
    chk(rd_valid == 1'b0 && wr_valid == 1'b0, "R10", "reset requests", {rd_valid, wr_valid}, 0);
    chk(err_flag == 1'b0, "R7", "reset error flag", err_flag, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_copy("R1 R2 R3 plain lines",     'h000, 'h800,  64, 4, 0, 4, 0, 0);
    run_copy("R2 R3 R4 uneven gaps",     'h040, 'h900, 200, 2, 1, 3, 2, 0);
    run_copy("R2 R3 narrow src wide dst",'h100, 'hA00, 160, 1, 3, 5, 3, 0);
    run_copy("R4 single short beat",     'h200, 'hB00,   5, 1, 0, 1, 0, 0);
    run_copy("R11 unaligned bases",      'h047, 'h80B,  50, 1, 2, 2, 1, 0);
    run_copy("R7 zero source width",     'h000, 'h800,  64, 0, 0, 4, 0, 0);
    run_copy("R7 zero dest width",       'h000, 'h800,  64, 4, 0, 0, 1, 0);
    run_copy("R8 zero total",            'h000, 'h800,   0, 2, 0, 2, 0, 0);
    run_copy("R9 start while busy",      'h000, 'hC00, 256, 3, 1, 2, 2, 1);

    for (int t = 0; t < 12; t++) begin
      run_copy("R2 R3 R5 random",
               int'($urandom_range(0, 63)) * 16 + int'($urandom_range(0, 15)),
               2048 + int'($urandom_range(0, 31)) * 16,
               int'($urandom_range(1, 300)),
               int'($urandom_range(1, 4)), int'($urandom_range(0, 3)),
               int'($urandom_range(1, 4)), int'($urandom_range(0, 3)), 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule